// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one clause-22 management transaction at a time on a two-wire MDC/MDIO link to a PHY. A host raises `start` for one cycle together with the direction, the PHY address, the register address and, for writes, the data word. The block then produces the management clock from the system clock, shifts out the serial frame, and for reads captures the 16-bit register value the PHY returns. When it finishes, it raises `done` for one cycle. At that point `rd_data` and `phy_ack` are valid.

The data pin is split into `mdio_o`, `mdio_oe` and `mdio_i` so that a pad wrapper can build the tri-state buffer. The MDC half period is a number of system clocks taken from `half_period` at start. The block never lets it fall below the `MIN_HALF` parameter. A read that gets no acknowledge still runs all of its data slots, so that other PHYs on the link stay aligned. The missing acknowledge appears on its own flag and the returned data is forced to zero.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy`, `done`, `phy_ack` are 0 and `rd_data` is 0.
- R2: A `start` seen while idle sets `busy` and opens the frame with 32 slots in which `mdio_oe`=1 and `mdio_o`=1.
- R3: Slots 32 to 45 are driven and carry, most significant bit first: the start pattern 01, then the opcode (10 for a read with `rd_nwr`=1, 01 for a write), then the 5-bit PHY address, then the 5-bit register address.
- R4: On a write, slots 46 and 47 drive the turnaround 1 then 0, and slots 48 to 63 drive `wr_data` MSB first. After a write, `phy_ack` is 0.
- R5: On a read, `mdio_oe` is 0 from slot 46 on. `mdio_i` is sampled once, at the MDC rising edge of slot 47, and a low level there sets `phy_ack`=1.
- R6: On an acknowledged read, `mdio_i` is sampled at the MDC rising edge of slots 48 to 63. The first sample is bit 15 of `rd_data`.
- R7: On a read without acknowledge, all 16 data slots are still clocked, `phy_ack` is 0 and `rd_data` is 0.
- R8: Slot 64 is one more MDC period with `mdio_oe`=0. When it ends, `done` pulses for exactly one cycle, `busy` clears and `mdio_oe` is 0.
- R9: Each slot has MDC low for H system clocks, then high for H. `mdio_o` changes only while MDC is low. `done` rises 130·H cycles after the clock edge that accepts `start`.
- R10: H is `half_period`, raised to `MIN_HALF` when smaller. It is latched at start, and later changes to the input do not affect the running frame.
- R11: A `start` pulse while `busy` is ignored. It changes neither the frame in progress nor the result, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transaction |
| rd_nwr | input | 1 | 1 selects read, 0 selects write |
| phy_addr | input | PHY_W | Target PHY address |
| reg_addr | input | REG_W | Target register address |
| wr_data | input | DATA_W | Data to write |
| half_period | input | DIV_W | MDC half period in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | DATA_W | Read result, zero on missing acknowledge |
| phy_ack | output | 1 | PHY acknowledged the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data pin |
| mdio_i | input | 1 | Serial data in from the pin |

## Verification
The bench sweeps reads and writes over many address and data patterns and several divider settings, including a setting below the floor. A clamp that did not work would show up as a short frame duration, and a wrong opcode or field order would show up as a mismatched serial bit in the frame. Unacknowledged reads are paired with a PHY model that leaves the line pulled high. A design that skipped the data slots would produce a short slot count, and a design that passed the sampled bits through would return 0xFFFF instead of zero. One transaction receives a second start pulse and a new divider value partway through. A design that restarted would produce a second frame or the wrong duration, and a design that did not latch its settings would also produce the wrong duration.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;

  localparam logic [1:0] SOF_PAT   = 2'b01;
  localparam logic [1:0] TA_WR_PAT = 2'b10;
  localparam int         FIXED_HDR = 4;   // start pattern + opcode
  localparam int         TA_BITS   = 2;

  function automatic int frame_len(int pre, int phy_w, int reg_w, int data_w);
    return pre + FIXED_HDR + phy_w + reg_w + TA_BITS + data_w;
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
module mdio_clk_gen #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] half_in,
  output logic             mdc,
  output logic             rise,
  output logic             slot_end
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);
  localparam logic [DIV_W:0]   ONE   = (DIV_W+1)'(1);

  logic [DIV_W-1:0] half_q;
  logic [DIV_W:0]   cnt;
  logic [DIV_W:0]   rise_at;
  logic [DIV_W:0]   last_at;
  logic [DIV_W-1:0] half_eff;

  assign half_eff = (half_in < MIN_V) ? MIN_V : half_in;
  assign rise_at  = {1'b0, half_q} - ONE;
  assign last_at  = {half_q, 1'b0} - ONE;
  assign rise     = run && (cnt == rise_at);
  assign slot_end = run && (cnt == last_at);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= MIN_V;
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (load) begin
      half_q <= half_eff;
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (run) begin
      if (slot_end) begin
        cnt <= '0;
        mdc <= 1'b0;
      end else begin
        cnt <= cnt + ONE;
        if (rise) mdc <= 1'b1;
      end
    end else begin
      cnt <= '0;
      mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int SLOT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic [PHY_W-1:0]  phy_addr,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slot_end,
  output logic              accept,
  output logic              finish,
  output logic              busy,
  output logic              done,
  output logic              is_read,
  output logic [SLOT_W-1:0] slot,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int FRAME_BITS = frame_len(PRE_LEN, PHY_W, REG_W, DATA_W);
  localparam logic [SLOT_W-1:0] HDR_END   = SLOT_W'(PRE_LEN + FIXED_HDR + PHY_W + REG_W);
  localparam logic [SLOT_W-1:0] IDLE_SLOT = SLOT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame_w;
  logic [FRAME_BITS-1:0] shreg;
  logic [SLOT_W-1:0]     nxt;
  logic                  oe_next;

  // Assemble the complete outgoing bit stream; read tail bits are never driven.
  always_comb begin
    frame_w = {{PRE_LEN{1'b1}}, SOF_PAT,
               (rd_nwr ? OPC_READ : OPC_WRITE),
               phy_addr, reg_addr,
               (rd_nwr ? 2'b00 : TA_WR_PAT),
               (rd_nwr ? {DATA_W{1'b0}} : wr_data)};
  end

  assign accept  = start && !busy;
  assign finish  = busy && slot_end && (slot == IDLE_SLOT);
  assign nxt     = slot + SLOT_W'(1);
  assign oe_next = (nxt < HDR_END) || (!is_read && (nxt < IDLE_SLOT));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      is_read <= 1'b0;
      slot    <= '0;
      shreg   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        is_read <= rd_nwr;
        slot    <= '0;
        mdio_o  <= frame_w[FRAME_BITS-1];
        mdio_oe <= 1'b1;
        shreg   <= {frame_w[FRAME_BITS-2:0], 1'b0};
      end else if (finish) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        mdio_o  <= 1'b0;
        mdio_oe <= 1'b0;
      end else if (busy && slot_end) begin
        slot    <= nxt;
        mdio_oe <= oe_next;
        mdio_o  <= oe_next & shreg[FRAME_BITS-1];
        shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/mdio_rd_capture.sv
`timescale 1ns/1ps
module mdio_rd_capture #(
  parameter int DATA_W     = 16,
  parameter int SLOT_W     = 7,
  parameter int ACK_SLOT   = 47,
  parameter int DATA_FIRST = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              is_read,
  input  logic              rise,
  input  logic [SLOT_W-1:0] slot,
  input  logic              mdio_i,
  input  logic              finish,
  output logic [DATA_W-1:0] rd_data,
  output logic              phy_ack
);
  localparam logic [SLOT_W-1:0] ACK_S = SLOT_W'(ACK_SLOT);
  localparam logic [SLOT_W-1:0] D_LO  = SLOT_W'(DATA_FIRST);
  localparam logic [SLOT_W-1:0] D_HI  = SLOT_W'(DATA_FIRST + DATA_W);

  logic              ack_q;
  logic [DATA_W-1:0] data_q;
  logic              in_data;

  assign in_data = (slot >= D_LO) && (slot < D_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      data_q  <= '0;
      rd_data <= '0;
      phy_ack <= 1'b0;
    end else begin
      if (clear) begin
        ack_q  <= 1'b0;
        data_q <= '0;
      end else if (rise && is_read) begin
        if (slot == ACK_S) ack_q <= ~mdio_i;
        if (in_data)       data_q <= {data_q[DATA_W-2:0], mdio_i};
      end
      if (finish) begin
        phy_ack <= is_read && ack_q;
        rd_data <= (is_read && ack_q) ? data_q : '0;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic [PHY_W-1:0]  phy_addr,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  half_period,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              phy_ack,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_BITS = frame_len(PRE_LEN, PHY_W, REG_W, DATA_W);
  localparam int SLOT_W     = $clog2(FRAME_BITS + 1);
  localparam int HDR_END    = PRE_LEN + FIXED_HDR + PHY_W + REG_W;
  localparam int ACK_SLOT   = HDR_END + 1;
  localparam int DATA_FIRST = HDR_END + TA_BITS;

  logic              accept;
  logic              finish;
  logic              is_read;
  logic              rise;
  logic              slot_end;
  logic [SLOT_W-1:0] slot;

  mdio_clk_gen #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_clk (
    .clk(clk), .rst(rst), .load(accept), .run(busy),
    .half_in(half_period), .mdc(mdc), .rise(rise), .slot_end(slot_end)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN), .PHY_W(PHY_W), .REG_W(REG_W),
                   .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .slot_end(slot_end), .accept(accept), .finish(finish),
    .busy(busy), .done(done), .is_read(is_read), .slot(slot),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_rd_capture #(.DATA_W(DATA_W), .SLOT_W(SLOT_W),
                    .ACK_SLOT(ACK_SLOT), .DATA_FIRST(DATA_FIRST)) u_cap (
    .clk(clk), .rst(rst), .clear(accept), .is_read(is_read), .rise(rise),
    .slot(slot), .mdio_i(mdio_i), .finish(finish),
    .rd_data(rd_data), .phy_ack(phy_ack)
  );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
  parameter int MIN_HALF = 20
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  logic [15:0] hi_cnt;
  logic [15:0] lo_cnt;

  // Run lengths of each MDC level, saturating.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= mdc ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
      lo_cnt <= mdc ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  assert_oe_rises_at_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> $rose(busy));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_released_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mdio_oe));

  assert_data_moves_low_R9: assert property (@(posedge clk) disable iff (rst)
    (mdio_o != $past(mdio_o)) |-> !mdc);

  assert_high_width_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(mdc) |-> (hi_cnt >= 16'(MIN_HALF)));

  assert_low_width_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> (lo_cnt >= 16'(MIN_HALF)));
endmodule

bind mdio_master mdio_master_chk #(.MIN_HALF(MIN_HALF)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int MINH = 2;
  localparam int DW   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_nwr = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [DW-1:0] half_period = '0;
  logic        busy, done, phy_ack, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  int   rise_cnt = 0;
  int   base = 0;
  logic rec_oe [0:79];
  logic rec_o  [0:79];
  logic        phy_ack_en = 1'b0;
  logic        phy_rd = 1'b0;
  logic [15:0] phy_resp = '0;

  always #5 clk = ~clk;

  mdio_master #(.DIV_W(DW), .MIN_HALF(MINH)) u_dut (
    .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .half_period(half_period), .busy(busy), .done(done),
    .rd_data(rd_data), .phy_ack(phy_ack), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // Line monitor: record pin state at each MDC rising edge.
  always @(posedge mdc) begin
    int idx;
    idx = rise_cnt - base;
    if (idx >= 0 && idx < 80) begin
      rec_oe[idx] = mdio_oe;
      rec_o[idx]  = mdio_o;
    end
    rise_cnt = rise_cnt + 1;
  end

  // PHY model: update the line while MDC is low for the slot now starting.
  always @(negedge mdc) begin
    int s;
    s = rise_cnt - base;
    if (phy_rd && phy_ack_en && s == 47)
      mdio_i = 1'b0;
    else if (phy_rd && phy_ack_en && s >= 48 && s <= 63)
      mdio_i = phy_resp[63-s];
    else
      mdio_i = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [DW-1:0] hp,
                         input logic ack_en, input logic [15:0] resp, input logic poke);
    logic [63:0] v;
    int h, cycles, bad_pre, bad_hdr, bad_tail, bad_idle;
    h = (hp < MINH) ? MINH : int'(hp);
    v = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra,
         (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : wd)};
    phy_rd = rd; phy_ack_en = ack_en; phy_resp = resp;
    base = rise_cnt;
    @(negedge clk);
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
    half_period = hp; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R2", {31'd0, busy}, 32'd1, "busy after start");
    cycles = 0;
    do begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (poke && cycles == 50) begin
        start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra;
        wr_data = ~wd; half_period = DW'(h + 3);
      end
      if (poke && cycles == 51) start = 1'b0;
    end while (!done && cycles < 5000);
    check("R9", cycles, 130 * h, "cycles start to done (R10 half clamp)");
    check("R8", {31'd0, busy}, 32'd0, "busy at done");
    if (rd) begin
      check(ack_en ? "R5" : "R7", {31'd0, phy_ack}, {31'd0, ack_en}, "ack flag");
      check(ack_en ? "R6" : "R7", {16'd0, rd_data}, ack_en ? {16'd0, resp} : 32'd0, "read data");
    end else begin
      check("R4", {31'd0, phy_ack}, 32'd0, "ack flag after write");
    end
    check("R9", rise_cnt - base, 65, "MDC rising edges per frame");
    bad_pre = 0; bad_hdr = 0; bad_tail = 0; bad_idle = 0;
    for (int k = 0; k < 65; k++) begin
      logic eoe, eo;
      eoe = (k < 46) || (!rd && k < 64);
      eo  = (k < 64) ? v[63-k] : 1'b0;
      if (rec_oe[k] !== eoe || (eoe && rec_o[k] !== eo)) begin
        if (k < 32) bad_pre++;
        else if (k < 46) bad_hdr++;
        else if (k < 64) bad_tail++;
        else bad_idle++;
      end
    end
    check("R2", bad_pre, 0, "preamble slot mismatches");
    check("R3", bad_hdr, 0, "header slot mismatches");
    check(rd ? "R5" : "R4", bad_tail, 0, "turnaround/data slot mismatches");
    check("R8", bad_idle, 0, "trailing idle slot mismatches");
    @(negedge clk);
    check("R8", {31'd0, done}, 32'd0, "done width");
    if (poke) begin
      repeat (6) @(negedge clk);
      check("R11", {30'd0, busy, mdc}, 32'd0, "no second transaction");
      check("R11", rise_cnt - base, 65, "no extra MDC edges");
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", {26'd0, mdc, mdio_oe, busy, done, phy_ack, 1'b0}, 32'd0, "control outputs");
    check("R1", {16'd0, rd_data}, 32'd0, "rd_data");
    for (int hp = 0; hp < 4; hp++) begin
      for (int i = 0; i < 6; i++) begin
        logic [4:0]  pa;
        logic [4:0]  ra;
        logic [15:0] d;
        pa = 5'(i * 7 + hp);
        ra = 5'(31 - i * 5);
        d  = 16'(16'hA5C3 ^ (i * 16'h1111) ^ (hp << 12));
        run_txn(1'b0, pa, ra, d, DW'(hp), 1'b0, 16'h0000, 1'b0);
        run_txn(1'b1, pa, ra, 16'h0000, DW'(hp), 1'b1, ~d, 1'b0);
        run_txn(1'b1, ra, pa, 16'h0000, DW'(hp), 1'b0, d, 1'b0);
      end
    end
    run_txn(1'b1, 5'd0, 5'd31, 16'h0000, DW'(2), 1'b1, 16'h8001, 1'b0);
    run_txn(1'b0, 5'd31, 5'd0, 16'hFFFF, DW'(3), 1'b0, 16'h0000, 1'b0);
    // R11 / R10: start pulse and new divider value during a busy frame
    run_txn(1'b0, 5'd9, 5'd18, 16'h3C5A, DW'(2), 1'b0, 16'h0000, 1'b1);
    run_txn(1'b1, 5'd20, 5'd3, 16'h0000, DW'(3), 1'b1, 16'h7E81, 1'b1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule